// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register Block

This block holds the host-visible control registers of a two-channel bus-master DMA engine for a disk controller. A host issues byte or dword I/O accesses; the block subtracts a programmable base address, decides whether the access lands in its window, and steers it to one of the channels. Each channel owns an 8-byte slice of the window: a command byte, a status byte and a dword-wide pointer to a descriptor table. Bytes with no register behind them read back as all ones.

The transfer engine of each channel sees the start and direction bits from the command byte. It reports back through three signals: a level saying that a transfer is in progress, and single-cycle pulses that raise the interrupt and error flags. The status byte combines host read/write bits, the engine-driven active bit and two flags that the host clears by writing ones.

The channel count `NUM_CH` must be a power of two and at least 2; the window is `NUM_CH * 8` bytes starting at `io_base`, which may sit at any address.

Top module: `bmdma_regs_top`

## Requirements
- R1: An access hits when `0 <= io_addr - io_base < NUM_CH*8`; channel c is selected by offsets 8c to 8c+7 and the low three bits of the difference give the byte offset. A miss returns `io_hit`=0 and `io_rdata`=0, and a write on a miss changes no register.
- R2: A byte read at offset 0 returns the command byte: bit 0 is the start bit, bit 3 the direction bit, every other bit reads 0. A byte write at offset 0 loads bits 0 and 3.
- R3: Byte reads at offsets 1, 3, 4, 5, 6 and 7 return 0xFF in `io_rdata[7:0]` (upper bits 0); byte writes at those offsets change no register.
- R4: A byte write at offset 2 loads status bits 6 and 5 directly from the written data.
- R5: Status bit 0 equals, one cycle later, the engine active level ANDed with the start bit as it stands after that cycle's writes; status writes never change it, and writing start to 0 clears it on the next cycle.
- R6: On a status write, bits 2 and 1 clear where the data has a 1 and hold where it has a 0.
- R7: Status bits 7, 4 and 3 always read 0.
- R8: A `eng_set_irq` pulse sets status bit 2 and a `eng_set_err` pulse sets bit 1; when a pulse and a clearing write meet in one cycle, the bit ends set.
- R9: A dword access at offset 4 reads and writes the descriptor pointer, whose bits 1:0 are forced to 0 on write. A dword read at any other offset returns 0xFFFFFFFF, and a dword write there changes nothing.
- R10: After reset every command, status and pointer register of every channel reads 0.
- R11: `eng_start[c]` and `eng_dir[c]` always equal command bits 0 and 3 of channel c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_base | input | ADDR_W | Base address of the register window |
| io_addr | input | ADDR_W | Host access address |
| io_rd | input | 1 | Host read strobe |
| io_wr | input | 1 | Host write strobe |
| io_dword | input | 1 | 1 for a dword access, 0 for a byte access |
| io_wdata | input | 32 | Write data (bytes in bits 7:0) |
| io_rdata | output | 32 | Read data, combinational |
| io_hit | output | 1 | Access falls inside the window |
| eng_active | input | NUM_CH | Per-channel transfer-in-progress level |
| eng_set_irq | input | NUM_CH | Per-channel pulse raising the interrupt flag |
| eng_set_err | input | NUM_CH | Per-channel pulse raising the error flag |
| eng_start | output | NUM_CH | Per-channel start bit |
| eng_dir | output | NUM_CH | Per-channel direction bit |

## Verification
A wrong flag or command bit inside a channel shows up at the ports on the very next read of that channel's status or command byte, and a wrong start or direction bit is visible on `eng_start`/`eng_dir` in the cycle after the write. Every status write value is swept against every combination of prior interrupt and error flags on both channels, so a broken merge rule shows within one read of the offending write. A decode error shows as a register of the wrong channel changing, or as a miss that answers, which the bench reads back right after each stray access.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

  localparam int unsigned SLOT_BYTES = 8;
  localparam logic [7:0]  FILL_BYTE  = 8'hFF;
  localparam logic [31:0] FILL_DWORD = 32'hFFFF_FFFF;

  localparam logic [2:0] OFF_CMD  = 3'd0;
  localparam logic [2:0] OFF_STAT = 3'd2;
  localparam logic [2:0] OFF_PTR  = 3'd4;

  // write-one-to-clear with a priority set
  function automatic logic flag_next(input logic cur, input logic wr,
                                     input logic wbit, input logic set);
    return set | (cur & ~(wr & wbit));
  endfunction

  function automatic logic [7:0] pack_status(input logic [1:0] rw65,
                                             input logic irq, input logic err,
                                             input logic act);
    return {1'b0, rw65, 2'b00, irq, err, act};
  endfunction

  function automatic logic [7:0] pack_cmd(input logic dir, input logic start);
    return {4'b0000, dir, 2'b00, start};
  endfunction

  function automatic logic [31:0] align_ptr(input logic [31:0] d);
    return {d[31:2], 2'b00};
  endfunction

endpackage

// File: rtl/bmdma_decode.sv
module bmdma_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              dword,
  output logic              hit,
  output logic [$clog2(NUM_CH)-1:0] ch_idx,
  output logic [2:0]        offset,
  output logic [NUM_CH-1:0] wr_cmd_v,
  output logic [NUM_CH-1:0] wr_stat_v,
  output logic [NUM_CH-1:0] wr_ptr_v
);
  import bmdma_pkg::*;

  localparam int unsigned IDX_W    = $clog2(NUM_CH);
  localparam int unsigned WIN_LOG2 = IDX_W + 3;
  localparam int unsigned WIN_SIZE = NUM_CH * SLOT_BYTES;

  logic [ADDR_W-1:0] diff;
  logic              wr_hit;

  assign diff   = addr - base;
  assign hit    = ({{(32-ADDR_W){1'b0}}, diff} < WIN_SIZE);
  assign ch_idx = diff[WIN_LOG2-1:3];
  assign offset = diff[2:0];
  assign wr_hit = wr & hit;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    logic mine;
    assign mine         = wr_hit & (ch_idx == IDX_W'(c));
    assign wr_cmd_v[c]  = mine & ~dword & (offset == OFF_CMD);
    assign wr_stat_v[c] = mine & ~dword & (offset == OFF_STAT);
    assign wr_ptr_v[c]  = mine &  dword & (offset == OFF_PTR);
  end

  // R1: at most one register strobe per access
  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_cmd_v, wr_stat_v, wr_ptr_v}));

  // R1: a miss never strobes a register
  a_r1_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> ({wr_cmd_v, wr_stat_v, wr_ptr_v} == '0));

endmodule

// File: rtl/bmdma_channel.sv
module bmdma_channel (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_cmd,
  input  logic        wr_stat,
  input  logic        wr_ptr,
  input  logic [31:0] wdata,
  input  logic        set_irq,
  input  logic        set_err,
  input  logic        active_in,
  output logic [7:0]  cmd_q,
  output logic [7:0]  stat_q,
  output logic [31:0] ptr_q,
  output logic        start,
  output logic        dir
);
  import bmdma_pkg::*;

  logic       start_q, dir_q, start_nxt;
  logic [1:0] rw65_q;
  logic       irq_q, err_q, act_q;
  logic [31:0] ptr_r;

  assign start_nxt = wr_cmd ? wdata[0] : start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      dir_q   <= 1'b0;
      rw65_q  <= 2'b00;
      irq_q   <= 1'b0;
      err_q   <= 1'b0;
      act_q   <= 1'b0;
      ptr_r   <= '0;
    end else begin
      start_q <= start_nxt;
      if (wr_cmd)  dir_q  <= wdata[3];
      if (wr_stat) rw65_q <= wdata[6:5];
      irq_q <= flag_next(irq_q, wr_stat, wdata[2], set_irq);
      err_q <= flag_next(err_q, wr_stat, wdata[1], set_err);
      act_q <= active_in & start_nxt;
      if (wr_ptr) ptr_r <= align_ptr(wdata);
    end
  end

  assign cmd_q  = pack_cmd(dir_q, start_q);
  assign stat_q = pack_status(rw65_q, irq_q, err_q, act_q);
  assign ptr_q  = ptr_r;
  assign start  = start_q;
  assign dir    = dir_q;

  a_r4_rw_bits: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> (stat_q[6:5] == $past(wdata[6:5])));

  a_r5_stop_drops_active: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !wdata[0]) |=> !stat_q[0]);

  a_r5_idle_engine: assert property (@(posedge clk) disable iff (!rst_n)
    !active_in |=> !stat_q[0]);

  a_r6_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wdata[1] && !set_err) |=> !stat_q[1]);

  a_r6_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wdata[2] && !set_irq) |=> !stat_q[2]);

  a_r8_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_irq |=> stat_q[2]);

  a_r8_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_err |=> stat_q[1]);

  a_r9_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr |=> (ptr_q == ($past(wdata) & 32'hFFFF_FFFC)));

  a_r11_start_follows: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |=> (start == $past(wdata[0]) && dir == $past(wdata[3])));

endmodule

// File: rtl/bmdma_regs_top.sv
module bmdma_regs_top #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_base,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic              io_dword,
  input  logic [31:0]       io_wdata,
  output logic [31:0]       io_rdata,
  output logic              io_hit,
  input  logic [NUM_CH-1:0] eng_active,
  input  logic [NUM_CH-1:0] eng_set_irq,
  input  logic [NUM_CH-1:0] eng_set_err,
  output logic [NUM_CH-1:0] eng_start,
  output logic [NUM_CH-1:0] eng_dir
);
  import bmdma_pkg::*;

  localparam int unsigned IDX_W = $clog2(NUM_CH);

  logic [IDX_W-1:0]  ch_idx;
  logic [2:0]        offset;
  logic [NUM_CH-1:0] wr_cmd_v, wr_stat_v, wr_ptr_v;
  logic [NUM_CH-1:0][7:0]  cmd_all, stat_all;
  logic [NUM_CH-1:0][31:0] ptr_all;

  bmdma_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .base      (io_base),
    .addr      (io_addr),
    .wr        (io_wr),
    .dword     (io_dword),
    .hit       (io_hit),
    .ch_idx    (ch_idx),
    .offset    (offset),
    .wr_cmd_v  (wr_cmd_v),
    .wr_stat_v (wr_stat_v),
    .wr_ptr_v  (wr_ptr_v)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    bmdma_channel u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_cmd    (wr_cmd_v[c]),
      .wr_stat   (wr_stat_v[c]),
      .wr_ptr    (wr_ptr_v[c]),
      .wdata     (io_wdata),
      .set_irq   (eng_set_irq[c]),
      .set_err   (eng_set_err[c]),
      .active_in (eng_active[c]),
      .cmd_q     (cmd_all[c]),
      .stat_q    (stat_all[c]),
      .ptr_q     (ptr_all[c]),
      .start     (eng_start[c]),
      .dir       (eng_dir[c])
    );
  end

  always_comb begin
    io_rdata = '0;
    if (io_rd && io_hit) begin
      if (io_dword) begin
        io_rdata = (offset == OFF_PTR) ? ptr_all[ch_idx] : FILL_DWORD;
      end else begin
        unique case (offset)
          OFF_CMD:  io_rdata = {24'h0, cmd_all[ch_idx]};
          OFF_STAT: io_rdata = {24'h0, stat_all[ch_idx]};
          default:  io_rdata = {24'h0, FILL_BYTE};
        endcase
      end
    end
  end

  a_r1_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !io_hit |-> (io_rdata == 32'h0));

  a_r3_fill_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_hit && !io_dword && offset[0]) |-> (io_rdata == 32'h0000_00FF));

  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_hit && !io_dword && offset == OFF_STAT) |->
      (io_rdata[7] == 1'b0 && io_rdata[4:3] == 2'b00));

endmodule

// File: tb/bmdma_regs_top_tb.sv
module bmdma_regs_top_tb_top;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned NUM_CH = 2;
  localparam logic [15:0] BASE = 16'h0CC4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] io_base = BASE, io_addr = '0;
  logic io_rd = 0, io_wr = 0, io_dword = 0;
  logic [31:0] io_wdata = '0, io_rdata;
  logic io_hit;
  logic [NUM_CH-1:0] eng_active = '0, eng_set_irq = '0, eng_set_err = '0;
  logic [NUM_CH-1:0] eng_start, eng_dir;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bmdma_regs_top #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr_acc(input logic [15:0] a, input logic [31:0] d, input logic dw);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_dword = dw; io_wr = 1;
    @(negedge clk);
    io_wr = 0;
  endtask

  task automatic rd_acc(input logic [15:0] a, input logic dw,
                        output logic [31:0] d, output logic h);
    @(negedge clk);
    io_addr = a; io_dword = dw; io_rd = 1;
    #1;
    d = io_rdata; h = io_hit;
    io_rd = 0;
  endtask

  function automatic logic [15:0] ch_base(input int c);
    return BASE + 16'(8 * c);
  endfunction

  task automatic pulse(input int c, input logic irq, input logic err);
    @(negedge clk);
    eng_set_irq[c] = irq; eng_set_err[c] = err;
    @(negedge clk);
    eng_set_irq = '0; eng_set_err = '0;
  endtask

  initial begin : main
    logic [31:0] d;
    logic h;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R10: reset values
    for (int c = 0; c < NUM_CH; c++) begin
      rd_acc(ch_base(c), 0, d, h); chk("R10 cmd", d, 0);
      rd_acc(ch_base(c) + 2, 0, d, h); chk("R10 stat", d, 0);
      rd_acc(ch_base(c) + 4, 1, d, h); chk("R10 ptr", d, 0);
    end

    // R2 / R11: command sweep
    for (int c = 0; c < NUM_CH; c++) begin
      for (int w = 0; w < 256; w++) begin
        wr_acc(ch_base(c), 32'(w), 0);
        rd_acc(ch_base(c), 0, d, h);
        chk("R2 cmd readback", d, 32'(w & 8'h09));
        chk("R11 start", 32'(eng_start[c]), 32'(w & 1));
        chk("R11 dir", 32'(eng_dir[c]), 32'((w >> 3) & 1));
      end
      wr_acc(ch_base(c), 0, 0);
    end

    // R4 R6 R7 R8: status sweep over prior flags and written value
    for (int c = 0; c < NUM_CH; c++) begin
      for (int p = 0; p < 4; p++) begin
        for (int w = 0; w < 256; w++) begin
          wr_acc(ch_base(c) + 2, 32'h06, 0);
          if (p != 0) pulse(c, p[1], p[0]);
          wr_acc(ch_base(c) + 2, 32'(w), 0);
          rd_acc(ch_base(c) + 2, 0, d, h);
          chk("R4 R6 R7 status merge", d,
              32'((w & 8'h60) | ((p << 1) & ~w & 8'h06)));
        end
      end
    end

    // R8: set beats clear in the same cycle
    wr_acc(ch_base(1) + 2, 32'h00, 0);
    @(negedge clk);
    io_addr = ch_base(1) + 2; io_wdata = 32'h06; io_dword = 0; io_wr = 1;
    eng_set_irq[1] = 1;
    @(negedge clk);
    io_wr = 0; eng_set_irq = '0;
    rd_acc(ch_base(1) + 2, 0, d, h);
    chk("R8 irq set wins", d, 32'h04);
    pulse(1, 1'b1, 1'b1);
    rd_acc(ch_base(1) + 2, 0, d, h);
    chk("R8 both flags set", d, 32'h06);
    rd_acc(ch_base(0) + 2, 0, d, h);
    chk("R1 other channel flags untouched", d, 32'h60);

    // R5: active bit
    eng_active[0] = 1;
    wr_acc(ch_base(0) + 2, 32'h00, 0);
    rd_acc(ch_base(0) + 2, 0, d, h);
    chk("R5 idle while stopped", d, 32'h00);
    wr_acc(ch_base(0), 32'h01, 0);
    rd_acc(ch_base(0) + 2, 0, d, h);
    chk("R5 active after start", d, 32'h01);
    wr_acc(ch_base(0) + 2, 32'h00, 0);
    rd_acc(ch_base(0) + 2, 0, d, h);
    chk("R5 status write keeps active", d, 32'h01);
    wr_acc(ch_base(0) + 2, 32'h01, 0);
    rd_acc(ch_base(0) + 2, 0, d, h);
    chk("R5 write one keeps active", d, 32'h01);
    eng_active[0] = 0;
    @(negedge clk);
    rd_acc(ch_base(0) + 2, 0, d, h);
    chk("R5 engine idle clears", d, 32'h00);
    eng_active[0] = 1;
    @(negedge clk);
    @(negedge clk);
    rd_acc(ch_base(0) + 2, 0, d, h);
    chk("R5 engine busy again", d, 32'h01);
    wr_acc(ch_base(0), 32'h00, 0);
    rd_acc(ch_base(0) + 2, 0, d, h);
    chk("R5 stop drops active", d, 32'h00);
    eng_active[0] = 0;

    // R9: descriptor pointer
    wr_acc(ch_base(0) + 4, 32'hDEAD_BEEF, 1);
    wr_acc(ch_base(1) + 4, 32'h1234_5677, 1);
    rd_acc(ch_base(0) + 4, 1, d, h); chk("R9 ptr0 aligned", d, 32'hDEAD_BEEC);
    rd_acc(ch_base(1) + 4, 1, d, h); chk("R9 ptr1 aligned", d, 32'h1234_5674);
    for (int o = 0; o < 8; o++) begin
      if (o != 4) begin
        rd_acc(ch_base(1) + 16'(o), 1, d, h); chk("R9 dword fill", d, 32'hFFFF_FFFF);
        wr_acc(ch_base(1) + 16'(o), 32'hFFFF_FFFF, 1);
      end
    end
    rd_acc(ch_base(1), 0, d, h); chk("R9 dword write ignored cmd", d, 0);
    rd_acc(ch_base(1) + 2, 0, d, h); chk("R9 dword write ignored stat", d, 32'h06);
    rd_acc(ch_base(1) + 4, 1, d, h); chk("R9 ptr kept", d, 32'h1234_5674);

    // R3: fill bytes and ignored byte writes
    for (int c = 0; c < NUM_CH; c++) begin
      for (int o = 0; o < 8; o++) begin
        if (o != 0 && o != 2) begin
          rd_acc(ch_base(c) + 16'(o), 0, d, h); chk("R3 fill byte", d, 32'hFF);
          wr_acc(ch_base(c) + 16'(o), 32'hFFFF_FFFF, 0);
        end
      end
    end
    rd_acc(ch_base(0) + 4, 1, d, h); chk("R3 ptr unchanged", d, 32'hDEAD_BEEC);
    rd_acc(ch_base(0), 0, d, h); chk("R3 cmd unchanged", d, 0);
    rd_acc(ch_base(0) + 2, 0, d, h); chk("R3 stat unchanged", d, 32'h00);

    // R1: window edges
    rd_acc(BASE - 1, 0, d, h); chk("R1 below miss", {31'h0, h}, 0); chk("R1 below data", d, 0);
    rd_acc(BASE + 16, 0, d, h); chk("R1 above miss", {31'h0, h}, 0); chk("R1 above data", d, 0);
    rd_acc(BASE + 15, 0, d, h); chk("R1 last byte hit", {31'h0, h}, 1);
    wr_acc(BASE + 16, 32'h09, 0);
    wr_acc(BASE - 8, 32'h09, 0);
    wr_acc(BASE + 20, 32'h0000_0010, 1);
    chk("R1 miss write start", 32'(eng_start), 0);
    rd_acc(ch_base(1) + 4, 1, d, h); chk("R1 ptr after miss", d, 32'h1234_5674);

    done = 1;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got=timeout exp=done");
    end
  end

  initial begin : finish_blk
    wait (done || $time > 600000);
    #10;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule